// File: doc/BRIEF.md
# Non-Overlapping Two-Phase Clock Generator

This block turns a slow reference clock into two phase signals for switched-capacitor circuits. The two phases are never high together. Phase one follows the low half of the reference and phase two follows the high half. Every switch-over passes through a dead interval of a programmable number of system-clock cycles. All logic runs synchronously on a fast system clock, so the dead interval is counted in cycles instead of being set by gate delays.

Each phase is produced in two versions. The early version drives the signal-independent switch and the late version drives the signal-dependent switch. Both versions rise on the same cycle, so no settling time is lost. The early version falls a programmable number of cycles before the late one, so the switch whose charge injection does not depend on the signal opens first. A phase rises only after the generator has seen every version of the opposite phase low, in the same way as a cross-coupled NOR pair.

The reference clock passes through a synchronizer before any decision is made. An enable input lets the generator wind down cleanly and resume cleanly.

Top module: `nonoverlap_clkgen`

## Requirements
- R1: While `rst` is high, and for the first two system-clock cycles after it is released, all four phase outputs are low. With `ck_in` low and `enable` high, `ph1_early` rises at the third rising edge of `clk` after `rst` is released.
- R2: Phase one (`ph1_early`/`ph1_late`) is started only while the synchronized reference is low, and phase two (`ph2_early`/`ph2_late`) only while it is high.
- R3: No version of phase one is ever high in the same cycle as any version of phase two.
- R4: When a phase ends, its early output falls first and its late output falls exactly LATE_CYCLES cycles later.
- R5: The early and late outputs of a phase rise on the same cycle. A late output never rises on its own.
- R6: A phase rises no sooner than NOVL_CYCLES cycles after the most recent falling edge of any early output.
- R7: If the reference toggles back while a dead interval is running, the interval still runs to its full NOVL_CYCLES length. A reference pulse that is shorter than the interval starts no phase of the opposite polarity.
- R8: When `enable` is low, the active phase ends through the normal early-then-late fall and no phase starts. When `enable` is high again, the phase that matches the current reference level rises on the next cycle.
- R9: The parameters must satisfy LATE_CYCLES ≥ 1, NOVL_CYCLES > LATE_CYCLES and SYNC_STAGES ≥ 2. Elaboration stops if they do not.
- R10: When each reference level is held longer than the synchronizer delay plus NOVL_CYCLES, exactly one phase pulse appears per level, and the pulses follow the order of the reference levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new phases to start when high |
| ck_in | input | 1 | Slow reference clock, asynchronous to `clk` |
| ph1_early | output | 1 | Phase one, early-falling version |
| ph1_late | output | 1 | Phase one, late-falling version |
| ph2_early | output | 1 | Phase two, early-falling version |
| ph2_late | output | 1 | Phase two, late-falling version |

## Verification
The bound checker watches every cycle for cross-phase overlap, for late outputs that rise without their early twin, for the exact early-to-late fall offset, and for the minimum dead interval before each rise. It uses its own fall counters for the last two checks. It also checks that reset clears all outputs. Only the bench scenarios can show the behaviours that depend on the reference history: the order of the phases against a queue of expected phases, the start-up delay after reset, an interval that is not shortened by a reference glitch, and the wind-down and resumption around `enable`.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PH1  = 2'd1,
      ST_PH2  = 2'd2,
      ST_GAP  = 2'd3
   } nvc_state_t;
endpackage

// File: rtl/nvc_sync.sv
module nvc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic d_sync,
   output logic d_valid
);
   logic [STAGES-1:0] chain;
   logic [STAGES-1:0] seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         seen  <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d_async};
         seen  <= {seen[STAGES-2:0], 1'b1};
      end
   end

   assign d_sync  = chain[STAGES-1];
   assign d_valid = seen[STAGES-1];
endmodule

// File: rtl/nvc_phase_fsm.sv
module nvc_phase_fsm
   import nvc_pkg::*;
#(
   parameter int NOVL_CYCLES = 4,
   parameter int CNT_W       = $clog2(NOVL_CYCLES + 1)
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       want_p1,
   input  logic       want_p2,
   output logic [1:0] act_next
);
   localparam logic [CNT_W-1:0] GapLast = CNT_W'(NOVL_CYCLES);

   nvc_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (want_p1)      state_d = ST_PH1;
            else if (want_p2) state_d = ST_PH2;
         end
         ST_PH1: begin
            if (!want_p1) begin
               state_d = ST_GAP;
               cnt_d   = CNT_W'(1);
            end
         end
         ST_PH2: begin
            if (!want_p2) begin
               state_d = ST_GAP;
               cnt_d   = CNT_W'(1);
            end
         end
         ST_GAP: begin
            if (cnt_q == GapLast) begin
               if (want_p1)      state_d = ST_PH1;
               else if (want_p2) state_d = ST_PH2;
               else              state_d = ST_IDLE;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign act_next = {state_d == ST_PH2, state_d == ST_PH1};
endmodule

// File: rtl/nvc_phase_out.sv
module nvc_phase_out #(
   parameter int LATE_CYCLES = 2,
   parameter int HOLD_W      = $clog2(LATE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic act_next,
   output logic early,
   output logic late
);
   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         early  <= 1'b0;
         late   <= 1'b0;
         hold_q <= '0;
      end else begin
         early <= act_next;
         if (act_next) begin
            hold_q <= HOLD_W'(LATE_CYCLES);
            late   <= 1'b1;
         end else if (hold_q != '0) begin
            hold_q <= hold_q - HOLD_W'(1);
            late   <= 1'b1;
         end else begin
            late   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nonoverlap_clkgen.sv
module nonoverlap_clkgen #(
   parameter int NOVL_CYCLES = 4,
   parameter int LATE_CYCLES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic enable,
   input  logic ck_in,
   output logic ph1_early,
   output logic ph1_late,
   output logic ph2_early,
   output logic ph2_late
);
   localparam int CntW  = $clog2(NOVL_CYCLES + 1);
   localparam int HoldW = $clog2(LATE_CYCLES + 1);

   // R9: parameter legality
   if (LATE_CYCLES < 1 || NOVL_CYCLES <= LATE_CYCLES || SYNC_STAGES < 2) begin : g_bad_params
      $error("nonoverlap_clkgen: need LATE_CYCLES>=1, NOVL_CYCLES>LATE_CYCLES, SYNC_STAGES>=2");
   end

   logic       ck_s, ck_ok;
   logic       want_p1, want_p2;
   logic [1:0] act_next;
   logic [1:0] early_v, late_v;

   nvc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_async(ck_in), .d_sync(ck_s), .d_valid(ck_ok)
   );

   // R2: the reference level picks the phase
   assign want_p1 = ck_ok & enable & ~ck_s;
   assign want_p2 = ck_ok & enable &  ck_s;

   nvc_phase_fsm #(.NOVL_CYCLES(NOVL_CYCLES), .CNT_W(CntW)) u_fsm (
      .clk(clk), .rst(rst), .want_p1(want_p1), .want_p2(want_p2), .act_next(act_next)
   );

   for (genvar g = 0; g < 2; g++) begin : g_phase
      nvc_phase_out #(.LATE_CYCLES(LATE_CYCLES), .HOLD_W(HoldW)) u_out (
         .clk(clk), .rst(rst), .act_next(act_next[g]),
         .early(early_v[g]), .late(late_v[g])
      );
   end

   assign ph1_early = early_v[0];
   assign ph1_late  = late_v[0];
   assign ph2_early = early_v[1];
   assign ph2_late  = late_v[1];
endmodule

// File: rtl/nvc_checker.sv
module nvc_checker #(
   parameter int NOVL_CYCLES = 4,
   parameter int LATE_CYCLES = 2
) (
   input logic clk,
   input logic rst,
   input logic p1e,
   input logic p1l,
   input logic p2e,
   input logic p2l
);
   localparam int CW = $clog2(NOVL_CYCLES + 1);
   localparam logic [CW-1:0] Sat = CW'(NOVL_CYCLES);

   logic [CW-1:0] since1, since2;

   always_ff @(posedge clk) begin
      if (rst) begin
         since1 <= Sat;
         since2 <= Sat;
      end else begin
         since1 <= p1e ? '0 : ((since1 == Sat) ? Sat : since1 + CW'(1));
         since2 <= p2e ? '0 : ((since2 == Sat) ? Sat : since2 + CW'(1));
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> !(p1e || p1l || p2e || p2l));

   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
      !((p1e || p1l) && (p2e || p2l)));

   assert_late_fall_p1_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(p1l) |-> (since1 == CW'(LATE_CYCLES)));
   assert_late_fall_p2_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(p2l) |-> (since2 == CW'(LATE_CYCLES)));

   assert_early_in_late_p1_R5: assert property (@(posedge clk) disable iff (rst)
      p1e |-> p1l);
   assert_early_in_late_p2_R5: assert property (@(posedge clk) disable iff (rst)
      p2e |-> p2l);
   assert_rise_together_p1_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(p1l) |-> $rose(p1e));
   assert_rise_together_p2_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(p2l) |-> $rose(p2e));

   assert_gap_p1_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(p1e) |-> (since1 == Sat && since2 == Sat));
   assert_gap_p2_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(p2e) |-> (since1 == Sat && since2 == Sat));
endmodule

bind nonoverlap_clkgen nvc_checker #(
   .NOVL_CYCLES(NOVL_CYCLES), .LATE_CYCLES(LATE_CYCLES)
) u_chk (
   .clk(clk), .rst(rst),
   .p1e(ph1_early), .p1l(ph1_late), .p2e(ph2_early), .p2l(ph2_late)
);

// File: tb/nonoverlap_clkgen_tb.sv
module nonoverlap_clkgen_tb;
   localparam int NOVL = 4;
   localparam int LATE = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enable = 1'b1;
   logic ck_in = 1'b0;
   logic ph1_early, ph1_late, ph2_early, ph2_late;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   bit mon_on = 0;
   bit sb_on = 0;
   int sbq[$];

   int cyc = 0;
   int last_efall = -1000;
   int efall[2] = '{-1000, -1000};
   int rises[2] = '{0, 0};
   int last_gap = 0;
   logic [1:0] prv_e = '0, prv_l = '0;

   always #2.5 clk = ~clk;

   nonoverlap_clkgen #(.NOVL_CYCLES(NOVL), .LATE_CYCLES(LATE), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .enable(enable), .ck_in(ck_in),
      .ph1_early(ph1_early), .ph1_late(ph1_late),
      .ph2_early(ph2_early), .ph2_late(ph2_late)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: pops expected phases and checks timing rules at every sample
   always @(negedge clk) begin
      if (mon_on) begin
         logic [1:0] ce, cl;
         cyc++;
         ce = {ph2_early, ph1_early};
         cl = {ph2_late, ph1_late};
         check(!((ce[0] | cl[0]) & (ce[1] | cl[1])), "R3 overlap", {ce, cl}, 0);
         for (int i = 0; i < 2; i++) begin
            if (ce[i] && !prv_e[i]) begin
               check(cl[i] && !prv_l[i], "R5 late rises with early", int'(cl[i]), 1);
               check(cyc - last_efall >= NOVL, "R6 gap length", cyc - last_efall, NOVL);
               last_gap = cyc - last_efall;
               rises[i]++;
               if (sb_on) begin
                  if (sbq.size() == 0) check(0, "R10 unexpected phase", i + 1, 0);
                  else begin
                     int exp_ph;
                     exp_ph = sbq.pop_front();
                     check(exp_ph == i + 1, "R10/R2 phase order", i + 1, exp_ph);
                  end
               end
            end
            if (cl[i] && !prv_l[i] && !ce[i])
               check(0, "R5 late rose alone", 1, 0);
            if (!ce[i] && prv_e[i]) begin
               efall[i] = cyc;
               last_efall = cyc;
            end
            if (!cl[i] && prv_l[i])
               check(cyc - efall[i] == LATE, "R4 late fall offset", cyc - efall[i], LATE);
         end
         prv_e = ce;
         prv_l = cl;
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int lvl;
      int p2_before;
      bit quiet;

      // R1: reset state and start-up delay
      repeat (3) @(negedge clk);
      check({ph1_early, ph1_late, ph2_early, ph2_late} == 4'b0, "R1 reset outputs",
            {ph1_early, ph1_late, ph2_early, ph2_late}, 0);
      sbq.push_back(1);
      sb_on = 1;
      mon_on = 1;
      rst = 1'b0;
      @(negedge clk);
      check(!ph1_early && !ph1_late, "R1 low one cycle after reset", int'(ph1_early), 0);
      @(negedge clk);
      check(!ph1_early && !ph1_late, "R1 low two cycles after reset", int'(ph1_early), 0);
      @(negedge clk);
      check(ph1_early && ph1_late, "R1 first phase on third edge", int'(ph1_early), 1);

      // R2/R10: scoreboard of phase order under slow random reference
      lvl = 0;
      repeat (20) @(negedge clk);
      for (int k = 0; k < 40; k++) begin
         lvl = 1 - lvl;
         sbq.push_back(lvl == 1 ? 2 : 1);
         ck_in = lvl[0];
         repeat ($urandom_range(NOVL + LATE + 8, 30)) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      check(sbq.size() == 0, "R10 all expected phases seen", sbq.size(), 0);
      sb_on = 0;

      // R8: enable drop while phase two is active
      ck_in = 1'b1;
      repeat (30) @(negedge clk);
      check(ph2_early && ph2_late, "R8 phase two active before disable", int'(ph2_early), 1);
      enable = 1'b0;
      repeat (NOVL + 4) @(negedge clk);
      quiet = 1;
      for (int k = 0; k < 12; k++) begin
         if (ph1_early | ph1_late | ph2_early | ph2_late) quiet = 0;
         @(negedge clk);
      end
      check(quiet, "R8 no phase while disabled", int'(quiet), 1);
      enable = 1'b1;
      @(negedge clk);
      check(ph2_early && ph2_late, "R8 resume on next cycle", int'(ph2_early), 1);

      // R7: short reference glitch during a running gap
      ck_in = 1'b0;
      repeat (30) @(negedge clk);
      check(ph1_early, "R7 phase one settled", int'(ph1_early), 1);
      p2_before = rises[1];
      ck_in = 1'b1;
      repeat (3) @(negedge clk);
      ck_in = 1'b0;
      repeat (30) @(negedge clk);
      check(rises[1] == p2_before, "R7 no phase two from glitch", rises[1] - p2_before, 0);
      check(last_gap == NOVL, "R7 gap kept full length", last_gap, NOVL);
      check(ph1_early && ph1_late, "R7 phase one back", int'(ph1_early), 1);

      // R3-R6 under fast random toggling (monitor checks every cycle)
      for (int k = 0; k < 300; k++) begin
         ck_in = ~ck_in;
         repeat ($urandom_range(1, 9)) @(negedge clk);
      end
      repeat (20) @(negedge clk);

      done = 1;
      summary();
      $finish;
   end
endmodule